// File: doc/BRIEF.md
# Indirect Configuration Register Window

This block is the host-side configuration store for a two-channel disk interface controller. Software reaches it through a four-location I/O window driven by a simple synchronous read/write port. One location holds a pointer that names a channel and a register index. A second location is the data port, which reads or writes the per-channel register named by the pointer. The remaining two locations carry the global registers. One is a guarded chip-test register that is write-only and shares its location with a read-only status byte. The other is an interrupt mask register that also reports live interrupt status and a strap input.

Each channel keeps seven indexed registers: a command-block base, a general configuration byte, a ten-bit readahead count split over two write-only indices together with a readahead enable and a self-clearing FIFO clear, a control-block base, and two timing bytes. If the pointer's autoincrement bit is set, the index advances after every data-port access, so a driver can stream a whole channel setup with back-to-back accesses. The block drives one interrupt output per channel. Each output is the masked raw interrupt, with its sense set by that channel's polarity bit.

Top module: `idx_cfg_bank`

## Requirements
- R1: After reset, channel 0 reads index 0 = 0x01F0, index 4 = 0x03F6, and channel 1 reads 0x0170 and 0x0376. Both channels read index 1 = 0x01, index 5 = 0xF5 and index 6 = 0xDE. The pointer, mask, test_mode, legacy_mode, ra_en, ra_cnt and fifo_clr all reset to zero.
- R2: A write to offset 1 sets the pointer: bit 7 = autoincrement, bit 3 = channel, bits 2-0 = index. A read of offset 1 returns those bits in the same positions, with all other bits zero.
- R3: Offset 0 reads or writes the selected register of the selected channel. Indices 0 and 4 are 16 bits wide. Indices 1, 5 and 6 are 8 bits wide and read zero in bits 15-8. Index 1 bit 2 is write-only and reads zero.
- R4: With autoincrement set, the index grows by one after every cycle in which offset 0 is read or written, and wraps from 7 to 0. The index does not change on accesses to other offsets, on idle cycles, or when autoincrement is clear.
- R5: A write to index 7 changes no register, and index 7 reads zero.
- R6: Indices 2 and 3 read zero. ra_cnt[10c+9:10c] = {index 3 bits 1-0, index 2 bits 7-0} of channel c, and ra_en[c] = index 3 bit 7 of channel c.
- R7: A write to index 3 with bit 6 set raises fifo_clr[c] of that channel for exactly the following cycle. The bit is not stored.
- R8: A write to offset 3 loads mask bits 1-0 (bit c masks channel c). A read of offset 3 returns {000, legacy_strap, bm_irq[1], raw_irq[1], mask[1], mask[0]}. Writes to bits 7-2 have no effect.
- R9: A write to offset 2 with bit 7 = 1 loads legacy_mode from bit 1 and test_mode from bit 0. With bit 7 = 0 the write is ignored. A read of offset 2 returns {000000, bm_irq[0], raw_irq[0]}.
- R10: irq_out[c] = (raw_irq[c] AND NOT mask[c]) XOR channel c index 1 bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Window offset: 0 data, 1 pointer, 2 test/status, 3 mask |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current offset and pointer |
| raw_irq | input | 2 | Raw per-channel drive interrupts |
| bm_irq | input | 2 | Per-channel bus-master interrupt status |
| legacy_strap | input | 1 | Legacy header strap, reported in the mask register |
| irq_out | output | 2 | Masked, polarity-adjusted channel interrupts |
| fifo_clr | output | 2 | One-cycle FIFO clear pulse per channel |
| ra_en | output | 2 | Readahead enable per channel |
| ra_cnt | output | 20 | Readahead count, 10 bits per channel |
| test_mode | output | 1 | Chip test mode |
| legacy_mode | output | 1 | Legacy compatible mode |

## Verification
The hardest condition to reach from the ports is the index wrapping through the unused slot 7 while autoincrement runs. To reach it, the bench streams a series of data-port reads and writes past index 6 and checks that slot 7 reads empty and absorbs a write before the index returns to 0. The write-only readahead indices can only be seen on ra_cnt and ra_en. A long run of mixed random accesses therefore interleaves pointer rewrites, guarded test writes, mask changes and toggling interrupt inputs, and a behavioural model checks every cycle for stray index steps and cross-channel writes.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  localparam int IX_CMD = 0;
  localparam int IX_GEN = 1;
  localparam int IX_RAL = 2;
  localparam int IX_RAH = 3;
  localparam int IX_CTL = 4;
  localparam int IX_DTM = 5;
  localparam int IX_CTM = 6;

  function automatic logic [15:0] cmd_base_rst(input int ch);
    return (ch == 0) ? 16'h01F0 : 16'h0170;
  endfunction

  function automatic logic [15:0] ctl_base_rst(input int ch);
    return (ch == 0) ? 16'h03F6 : 16'h0376;
  endfunction

  function automatic logic irq_level(input logic raw, input logic msk, input logic pol);
    return (raw & ~msk) ^ pol;
  endfunction
endpackage

// File: rtl/cfgw_pointer.sv
module cfgw_pointer #(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_wr,
  input  logic          w_auto,
  input  logic          w_chan,
  input  logic [IW-1:0] w_idx,
  input  logic          data_acc,
  output logic          auto_inc,
  output logic          chan,
  output logic [IW-1:0] idx
);
  logic step_evt;
  assign step_evt = data_acc & auto_inc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      auto_inc <= 1'b0;
      chan     <= 1'b0;
      idx      <= '0;
    end else if (ptr_wr) begin
      auto_inc <= w_auto;
      chan     <= w_chan;
      idx      <= w_idx;
    end else if (step_evt) begin
      idx <= idx + 1'b1;
    end
  end

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> idx == IW'($past(idx) + 1'b1));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_acc && !ptr_wr) |=> $stable(idx));
endmodule

// File: rtl/cfgw_chan.sv
module cfgw_chan
  import cfgw_pkg::*;
#(
  parameter int CH  = 0,
  parameter int DW  = 16,
  parameter int IW  = 3,
  parameter int RAW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [IW-1:0]  idx,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic [RAW-1:0] ra_cnt,
  output logic           ra_en,
  output logic           fifo_clr,
  output logic           polarity
);
  localparam int HIW = RAW - 8;

  logic [DW-1:0]  cmd_base, ctl_base;
  logic [7:0]     gen_cfg, ra_lo, dtm, ctm;
  logic [HIW-1:0] ra_hi;
  logic           ra_on;
  logic           wr_ra_hi;

  assign wr_ra_hi = wr_en && (idx == IW'(IX_RAH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_base <= DW'(cmd_base_rst(CH));
      ctl_base <= DW'(ctl_base_rst(CH));
      gen_cfg  <= 8'h01;
      ra_lo    <= 8'h00;
      ra_hi    <= '0;
      ra_on    <= 1'b0;
      dtm      <= 8'hF5;
      ctm      <= 8'hDE;
      fifo_clr <= 1'b0;
    end else begin
      fifo_clr <= wr_ra_hi & wdata[6];
      if (wr_en) begin
        case (idx)
          IW'(IX_CMD): cmd_base <= wdata;
          IW'(IX_GEN): gen_cfg  <= wdata[7:0] & 8'hFB;
          IW'(IX_RAL): ra_lo    <= wdata[7:0];
          IW'(IX_RAH): begin
            ra_hi <= wdata[HIW-1:0];
            ra_on <= wdata[7];
          end
          IW'(IX_CTL): ctl_base <= wdata;
          IW'(IX_DTM): dtm      <= wdata[7:0];
          IW'(IX_CTM): ctm      <= wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx)
      IW'(IX_CMD): rdata = cmd_base;
      IW'(IX_GEN): rdata = DW'(gen_cfg);
      IW'(IX_CTL): rdata = ctl_base;
      IW'(IX_DTM): rdata = DW'(dtm);
      IW'(IX_CTM): rdata = DW'(ctm);
      default:     rdata = '0;
    endcase
  end

  assign ra_cnt   = {ra_hi, ra_lo};
  assign ra_en    = ra_on;
  assign polarity = gen_cfg[3];

  p_slot7_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IW'(7)) |=> $stable({cmd_base, ctl_base, gen_cfg, ra_lo, ra_hi, ra_on, dtm, ctm}));
  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_clr && !wr_en) |=> !fifo_clr);
endmodule

// File: rtl/cfgw_glob.sv
module cfgw_glob
  import cfgw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ct_wr,
  input  logic       mask_wr,
  input  logic       w_key,
  input  logic [1:0] w_low,
  input  logic [1:0] raw_irq,
  input  logic [1:0] bm_irq,
  input  logic       strap,
  input  logic [1:0] pol,
  output logic [7:0] stat_byte,
  output logic [7:0] mask_byte,
  output logic [1:0] irq_out,
  output logic       test_mode,
  output logic       legacy_mode
);
  logic [1:0] mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask        <= 2'b00;
      test_mode   <= 1'b0;
      legacy_mode <= 1'b0;
    end else begin
      if (mask_wr) mask <= w_low;
      if (ct_wr && w_key) begin
        legacy_mode <= w_low[1];
        test_mode   <= w_low[0];
      end
    end
  end

  assign stat_byte = {6'b0, bm_irq[0], raw_irq[0]};
  assign mask_byte = {3'b0, strap, bm_irq[1], raw_irq[1], mask};

  for (genvar c = 0; c < 2; c++) begin : g_irq
    assign irq_out[c] = irq_level(raw_irq[c], mask[c], pol[c]);
  end

  p_ct_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ct_wr && !w_key) |=> $stable({legacy_mode, test_mode}));
  p_mask_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> mask == $past(w_low));
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & mask & ~pol) == 2'b00);
endmodule

// File: rtl/idx_cfg_bank.sv
module idx_cfg_bank #(
  parameter int DW  = 16,
  parameter int IW  = 3,
  parameter int RAW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [1:0]       raw_irq,
  input  logic [1:0]       bm_irq,
  input  logic             legacy_strap,
  output logic [1:0]       irq_out,
  output logic [1:0]       fifo_clr,
  output logic [1:0]       ra_en,
  output logic [2*RAW-1:0] ra_cnt,
  output logic             test_mode,
  output logic             legacy_mode
);
  localparam int NCH = 2;

  logic          data_acc, data_wr;
  logic          p_auto, p_chan;
  logic [IW-1:0] p_idx;
  logic [NCH-1:0][DW-1:0] ch_rd;
  logic [NCH-1:0] pol;
  logic [7:0]    stat_byte, mask_byte;

  assign data_acc = (bus_rd | bus_wr) && (bus_sel == 2'd0);
  assign data_wr  = bus_wr && (bus_sel == 2'd0);

  cfgw_pointer #(.IW(IW)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .ptr_wr(bus_wr && bus_sel == 2'd1),
    .w_auto(bus_wdata[7]), .w_chan(bus_wdata[3]), .w_idx(bus_wdata[IW-1:0]),
    .data_acc(data_acc),
    .auto_inc(p_auto), .chan(p_chan), .idx(p_idx)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cfgw_chan #(.CH(c), .DW(DW), .IW(IW), .RAW(RAW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_en(data_wr && (p_chan == c[0])),
      .idx(p_idx), .wdata(bus_wdata),
      .rdata(ch_rd[c]),
      .ra_cnt(ra_cnt[c*RAW +: RAW]),
      .ra_en(ra_en[c]),
      .fifo_clr(fifo_clr[c]),
      .polarity(pol[c])
    );
  end

  cfgw_glob u_glob (
    .clk(clk), .rst_n(rst_n),
    .ct_wr(bus_wr && bus_sel == 2'd2),
    .mask_wr(bus_wr && bus_sel == 2'd3),
    .w_key(bus_wdata[7]), .w_low(bus_wdata[1:0]),
    .raw_irq(raw_irq), .bm_irq(bm_irq), .strap(legacy_strap), .pol(pol),
    .stat_byte(stat_byte), .mask_byte(mask_byte), .irq_out(irq_out),
    .test_mode(test_mode), .legacy_mode(legacy_mode)
  );

  always_comb begin
    case (bus_sel)
      2'd0:    bus_rdata = ch_rd[p_chan];
      2'd1:    bus_rdata = DW'({p_auto, 3'b000, p_chan, p_idx});
      2'd2:    bus_rdata = DW'(stat_byte);
      default: bus_rdata = DW'(mask_byte);
    endcase
  end

  p_chan_iso_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && p_chan) |=> $stable(ch_rd[0]) || p_idx != $past(p_idx));
endmodule

// File: tb/sim_idx_cfg_bank.sv
module sim_idx_cfg_bank;
  logic clk = 0, rst_n = 0;
  logic [1:0] bus_sel = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic [1:0] raw_irq = 0, bm_irq = 0;
  logic legacy_strap = 1;
  logic [1:0] irq_out, fifo_clr, ra_en;
  logic [19:0] ra_cnt;
  logic test_mode, legacy_mode;

  always #10 clk = ~clk;

  idx_cfg_bank u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference state
  int cmdb[2], gen[2], ral[2], rah[2], raon[2], ctlb[2], t5[2], t6[2], fc[2];
  int m_auto, m_chan, m_idx, m_mask, m_test, m_leg;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic m_reset();
    cmdb = '{'h1F0, 'h170}; ctlb = '{'h3F6, 'h376};
    for (int c = 0; c < 2; c++) begin
      gen[c] = 1; ral[c] = 0; rah[c] = 0; raon[c] = 0; t5[c] = 'hF5; t6[c] = 'hDE; fc[c] = 0;
    end
    m_auto = 0; m_chan = 0; m_idx = 0; m_mask = 0; m_test = 0; m_leg = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      int d;
      d = bus_wdata;
      fc[0] = 0; fc[1] = 0;
      if (bus_wr && bus_sel == 1) begin
        m_auto = (d >> 7) & 1; m_chan = (d >> 3) & 1; m_idx = d & 7;
      end
      if (bus_wr && bus_sel == 2 && ((d >> 7) & 1)) begin
        m_leg = (d >> 1) & 1; m_test = d & 1;
      end
      if (bus_wr && bus_sel == 3) m_mask = d & 3;
      if (bus_sel == 0 && bus_wr) begin
        case (m_idx)
          0: cmdb[m_chan] = d;
          1: gen[m_chan] = d & 'hFB;
          2: ral[m_chan] = d & 'hFF;
          3: begin rah[m_chan] = d & 3; raon[m_chan] = (d >> 7) & 1; fc[m_chan] = (d >> 6) & 1; end
          4: ctlb[m_chan] = d;
          5: t5[m_chan] = d & 'hFF;
          6: t6[m_chan] = d & 'hFF;
          default: ;
        endcase
      end
      if (bus_sel == 0 && (bus_wr || bus_rd) && m_auto) m_idx = (m_idx + 1) % 8;
    end
  end

  function automatic int m_read();
    case (bus_sel)
      0: case (m_idx)
           0: return cmdb[m_chan];
           1: return gen[m_chan];
           4: return ctlb[m_chan];
           5: return t5[m_chan];
           6: return t6[m_chan];
           default: return 0;
         endcase
      1: return (m_auto << 7) | (m_chan << 3) | m_idx;
      2: return (bm_irq[0] << 1) | raw_irq[0];
      default: return (legacy_strap << 4) | (bm_irq[1] << 3) | (raw_irq[1] << 2) | m_mask;
    endcase
  endfunction

  task automatic compare_all();
    string t;
    if (bus_sel == 0) t = (m_idx == 7) ? "R5 slot7 read" : (m_idx == 2 || m_idx == 3) ? "R6 wonly read" : "R3 data read";
    else if (bus_sel == 1) t = "R2 pointer read";
    else if (bus_sel == 2) t = "R9 status read";
    else t = "R8 mask read";
    chk(t, bus_rdata, m_read());
    for (int c = 0; c < 2; c++) begin
      chk("R10 irq_out", irq_out[c], ((raw_irq[c] & ~((m_mask >> c) & 1)) ^ ((gen[c] >> 3) & 1)) & 1);
      chk("R7 fifo_clr", fifo_clr[c], fc[c]);
      chk("R6 ra_cnt", ra_cnt[c*10 +: 10], (rah[c] << 8) | ral[c]);
      chk("R6 ra_en", ra_en[c], raon[c]);
    end
    chk("R9 test_mode", test_mode, m_test);
    chk("R9 legacy_mode", legacy_mode, m_leg);
  endtask

  task automatic bus(int sel, bit wr, bit rd, int d);
    @(negedge clk);
    bus_sel = 2'(sel); bus_wr = wr; bus_rd = rd; bus_wdata = 16'(d);
    #1 compare_all();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    int exp0[7] = '{'h1F0, 'h01, 0, 0, 'h3F6, 'hF5, 'hDE};
    int exp1[7] = '{'h170, 'h01, 0, 0, 'h376, 'hF5, 'hDE};
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state through the ports
    bus(1, 0, 1, 0);
    chk("R1 pointer reset", bus_rdata, 0);
    chk("R1 outputs reset", {test_mode, legacy_mode, fifo_clr, ra_en}, 0);
    chk("R1 ra_cnt reset", ra_cnt, 0);
    bus(3, 0, 1, 0);
    chk("R1 mask reset", bus_rdata & 3, 0);
    bus(1, 1, 0, 'h80);
    for (int i = 0; i < 7; i++) begin
      bus(0, 0, 1, 0);
      chk("R1 ch0 default", bus_rdata, exp0[i]);
    end
    // R4 wrap through slot 7 (R5)
    bus(0, 0, 1, 0);
    chk("R5 slot7 zero", bus_rdata, 0);
    bus(1, 0, 1, 0);
    chk("R4 wrapped index", bus_rdata, 'h80);
    bus(1, 1, 0, 'h88);
    for (int i = 0; i < 7; i++) begin
      bus(0, 0, 1, 0);
      chk("R1 ch1 default", bus_rdata, exp1[i]);
    end
    // R5 write into slot 7 of channel 1, then reread index 0
    bus(0, 1, 0, 'hFFFF);
    bus(0, 0, 1, 0);
    chk("R5 slot7 write ignored", bus_rdata, 'h170);
    // R4 no step without autoincrement
    bus(1, 1, 0, 'h05);
    bus(0, 0, 1, 0);
    bus(0, 1, 0, 'h33);
    bus(1, 0, 1, 0);
    chk("R4 no step", bus_rdata, 'h05);
    // R7 / R6 readahead on channel 0
    bus(1, 1, 0, 'h82);
    bus(0, 1, 0, 'h5A);
    bus(0, 1, 0, 'hC3);
    bus(0, 0, 0, 0);
    chk("R7 pulse cycle", fifo_clr, 2'b01);
    chk("R6 ra_cnt ch0", ra_cnt[9:0], 'h35A);
    bus(0, 0, 0, 0);
    chk("R7 pulse gone", fifo_clr, 2'b00);
    // R9 guard
    bus(2, 1, 0, 'h03);
    bus(2, 0, 1, 0);
    chk("R9 guarded", {legacy_mode, test_mode}, 0);
    bus(2, 1, 0, 'h83);
    bus(2, 0, 1, 0);
    chk("R9 accepted", {legacy_mode, test_mode}, 3);
    // R10 polarity on channel 1 with mask
    bus(1, 1, 0, 'h09);
    bus(0, 1, 0, 'h09);
    bus(3, 1, 0, 'hFE);
    raw_irq = 2'b10;
    bus(3, 0, 1, 0);
    chk("R8 mask readback", bus_rdata, 'h16);
    chk("R10 masked active-low", irq_out[1], 1);
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int s, k;
      s = $urandom_range(0, 3);
      k = $urandom_range(0, 2);
      raw_irq = 2'($urandom); bm_irq = 2'($urandom); legacy_strap = 1'($urandom);
      bus(s, k == 1, k == 2, $urandom);
    end
    bus(0, 0, 0, 0);
    summary();
  end
endmodule